// File: doc/BRIEF.md
# Passive Parallel Host Port

This block is a slave data port through which an outside host moves words into and out of the chip. The host drives every strobe. A host write fills an input holding register that internal logic later consumes. Internal logic fills an output holding register that the host later reads. Two flag pins tell the host whether fresh input is still waiting and whether the output register has already been drained. The same flags can also be read back as a status word over the data bus.

A small control register, written from the internal side, sets two things. The first is the host bus style: either separate read and write strobes, or one data strobe plus a direction line. The second is the external data width, 16 bits or 8 bits. On an 8-bit bus the host moves either single right-justified bytes or 16-bit words sent as two bytes, and a byte-select pin picks which half each access touches. While the status-select pin is high, host reads return the status word instead of data, and host writes are dropped.

All host pins are treated as synchronous to the block clock. An access takes effect on the first clock at which its strobe is found low after having been high.

Top module: `hpp_host_port`

## Requirements
- R1: After reset, `in_full` is 0, `out_empty` is 1, and the status word reads 0x0002. The control register resets to 0: split strobes, 16-bit bus.
- R2: Control bit0 = 0 selects split strobes: a falling `hst_rd_ds_n` is a read and a falling `hst_wr_rw` is a write. With control bit1 = 0, a write loads all 16 bits of `hst_din` into the input register and sets `in_full`.
- R3: Control bit0 = 1 selects one data strobe on `hst_rd_ds_n`, with `hst_wr_rw` as the direction (1 = read, 0 = write). In this mode, changes on `hst_wr_rw` alone cause no access.
- R4: Control bit1 = 1 with bit2 = 0 selects single bytes on an 8-bit bus. A write stores `{8'h00, hst_din[7:0]}` and sets `in_full`. A read returns `{8'h00, out[7:0]}` and sets `out_empty`.
- R5: Control bit1 = 1 with bit2 = 1 selects 16-bit words on an 8-bit bus. Each write stores `hst_din[7:0]` in the half picked by `hst_hi_byte` (1 = bits 15:8) and leaves the other half intact. `in_full` sets only on the second byte write.
- R6: In the same mode, each read returns the picked half right-justified with zeros above. `out_empty` sets only on the second byte read.
- R7: A pulse on `int_in_rd` clears `in_full`. A pulse on `int_out_wr` loads `int_out_data`, clears `out_empty` and clears the underrun bit.
- R8: A host data read while `out_empty` is 1 returns the last output value, leaves both flags unchanged, and sets status bit2 (underrun).
- R9: While `hst_stat_sel` is 1, a host read returns the status word (bit0 `in_full`, bit1 `out_empty`, bit2 underrun, all other bits 0) and changes no flag. A host write is ignored.
- R10: In 16-bit bus mode, one host data read of a full output register sets `out_empty`. `hst_hi_byte` has no effect in this mode.
- R11: A control write discards any half-finished byte pair, so the next byte starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_rd_ds_n | input | 1 | Read strobe (split style) or data strobe (single style), active low |
| hst_wr_rw | input | 1 | Write strobe, active low (split style), or direction, 1 = read (single style) |
| hst_hi_byte | input | 1 | Byte select on an 8-bit bus, 1 = high byte |
| hst_stat_sel | input | 1 | Status select, active high |
| hst_din | input | 16 | Host write data |
| hst_dout | output | 16 | Host read data or status word |
| in_full | output | 1 | Input register holds unconsumed data |
| out_empty | output | 1 | Output register has been read out |
| int_ctl_wr | input | 1 | Control register write pulse |
| int_ctl_data | input | 3 | Control value: bit0 style, bit1 8-bit bus, bit2 16-bit words |
| int_in_rd | input | 1 | Internal consume pulse for the input register |
| int_in_data | output | 16 | Input register contents |
| int_out_wr | input | 1 | Internal load pulse for the output register |
| int_out_data | input | 16 | Output register load value |

## Verification
The assertions assume that the host holds each strobe high for at least one clock between accesses. In split style they assume that read and write never fall in the same clock. They also assume that no host access lands in the same clock as an internal load, an internal consume, or a control write, because the block gives no ordering for such collisions. The bench keeps to these limits by running one operation at a time. Each host strobe is held low for exactly one clock and then released, and random operations are drawn one per slot, so no two ever overlap.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

  typedef enum logic {
    BUS_SPLIT     = 1'b0,
    BUS_DIRSTROBE = 1'b1
  } bus_style_e;

  // bit2 word16, bit1 narrow bus, bit0 bus style
  typedef struct packed {
    logic       word16;
    logic       narrow;
    bus_style_e style;
  } ctl_t;

  localparam int CTL_W    = 3;
  localparam int ST_FULL  = 0;
  localparam int ST_EMPTY = 1;
  localparam int ST_UNDER = 2;

endpackage

// File: rtl/hpp_strobe_dec.sv
module hpp_strobe_dec
  import hpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_style_e style,
  input  logic       rd_ds_n,
  input  logic       wr_rw,
  input  logic       stat_sel,
  output logic       data_rd_evt,
  output logic       data_wr_evt,
  output logic       stat_rd_evt
);

  logic prev_a_q, prev_a_d;
  logic prev_b_q, prev_b_d;
  logic a_fall, b_fall;
  logic rd_any, wr_any;

  always_comb begin
    prev_a_d = rd_ds_n;
    prev_b_d = wr_rw;
    a_fall   = prev_a_q & ~rd_ds_n;
    b_fall   = prev_b_q & ~wr_rw;
    if (style == BUS_SPLIT) begin
      rd_any = a_fall;
      wr_any = b_fall;
    end else begin
      rd_any = a_fall & wr_rw;
      wr_any = a_fall & ~wr_rw;
    end
    data_rd_evt = rd_any & ~stat_sel;
    data_wr_evt = wr_any & ~stat_sel;
    stat_rd_evt = rd_any & stat_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q <= 1'b1;
      prev_b_q <= 1'b1;
    end else begin
      prev_a_q <= prev_a_d;
      prev_b_q <= prev_b_d;
    end
  end

  // R3: a data strobe held low produces no further access
  assert_one_access_per_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (style == BUS_DIRSTROBE && !rd_ds_n && $past(!rd_ds_n)) |-> !(data_rd_evt || data_wr_evt));

  // R9: status select blocks data accesses
  assert_stat_blocks_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |-> !(data_rd_evt || data_wr_evt));

endmodule

// File: rtl/hpp_in_path.sv
module hpp_in_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              narrow,
  input  logic              word16,
  input  logic              hi_byte,
  input  logic [DATA_W-1:0] din,
  input  logic              int_rd,
  input  logic              clr_pair,
  output logic [DATA_W-1:0] in_data,
  output logic              in_full
);

  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] reg_q, reg_d;
  logic              full_q, full_d;
  logic              pend_q, pend_d;
  logic              load_en;

  always_comb begin
    reg_d  = reg_q;
    full_d = full_q;
    pend_d = pend_q;
    if (int_rd)   full_d = 1'b0;
    if (clr_pair) pend_d = 1'b0;
    if (wr_evt) begin
      if (!narrow) begin
        reg_d  = din;
        full_d = 1'b1;
      end else if (!word16) begin
        reg_d  = {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};
        full_d = 1'b1;
      end else begin
        if (hi_byte) reg_d[DATA_W-1:BYTE_W] = din[BYTE_W-1:0];
        else         reg_d[BYTE_W-1:0]      = din[BYTE_W-1:0];
        if (pend_q) begin
          full_d = 1'b1;
          pend_d = 1'b0;
        end else begin
          pend_d = 1'b1;
        end
      end
    end
    load_en = wr_evt | int_rd | clr_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (load_en) begin
      reg_q  <= reg_d;
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  assign in_data = reg_q;
  assign in_full = full_q;

  // R2: the full flag rises only on a host write
  assert_full_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_full && !wr_evt) |=> !in_full);

  // R7: consuming clears the full flag
  assert_consume_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rd && !wr_evt) |=> !in_full);

  // R5: the first byte of a pair leaves the full flag low
  assert_first_byte_no_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && narrow && word16 && !pend_q && !in_full && !clr_pair) |=> !in_full);

endmodule

// File: rtl/hpp_out_path.sv
module hpp_out_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              narrow,
  input  logic              word16,
  input  logic              hi_byte,
  input  logic              int_wr,
  input  logic [DATA_W-1:0] int_data,
  input  logic              clr_pair,
  output logic [DATA_W-1:0] rd_view,
  output logic              out_empty,
  output logic              underrun
);

  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] reg_q, reg_d;
  logic              empty_q, empty_d;
  logic              und_q, und_d;
  logic              pend_q, pend_d;
  logic              load_en;

  always_comb begin
    reg_d   = reg_q;
    empty_d = empty_q;
    und_d   = und_q;
    pend_d  = pend_q;
    if (rd_evt) begin
      if (empty_q) begin
        und_d = 1'b1;
      end else if (narrow && word16) begin
        if (pend_q) begin
          empty_d = 1'b1;
          pend_d  = 1'b0;
        end else begin
          pend_d = 1'b1;
        end
      end else begin
        empty_d = 1'b1;
      end
    end
    if (clr_pair) pend_d = 1'b0;
    if (int_wr) begin
      reg_d   = int_data;
      empty_d = 1'b0;
      und_d   = 1'b0;
      pend_d  = 1'b0;
    end
    load_en = rd_evt | int_wr | clr_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      empty_q <= 1'b1;
      und_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (load_en) begin
      reg_q   <= reg_d;
      empty_q <= empty_d;
      und_q   <= und_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    if (!narrow)
      rd_view = reg_q;
    else if (word16 && hi_byte)
      rd_view = {{BYTE_W{1'b0}}, reg_q[DATA_W-1:BYTE_W]};
    else
      rd_view = {{BYTE_W{1'b0}}, reg_q[BYTE_W-1:0]};
  end

  assign out_empty = empty_q;
  assign underrun  = und_q;

  // R7: an internal load makes the register fresh
  assert_load_refreshes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr |=> (!out_empty && !underrun));

  // R8: reading an empty register keeps it empty and flags underrun
  assert_underrun_on_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && out_empty && !int_wr) |=> (out_empty && underrun));

  // R8: underrun rises only from a read of an empty register
  assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(out_empty) && $past(rd_evt)));

  // R6: the first byte read of a pair keeps the register full
  assert_first_byte_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !out_empty && narrow && word16 && !pend_q && !clr_pair) |=> !out_empty);

  // R10: a full-width read drains the register
  assert_wide_read_drains_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !out_empty && !narrow && !int_wr) |=> out_empty);

endmodule

// File: rtl/hpp_host_port.sv
module hpp_host_port
  import hpp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_rd_ds_n,
  input  logic              hst_wr_rw,
  input  logic              hst_hi_byte,
  input  logic              hst_stat_sel,
  input  logic [DATA_W-1:0] hst_din,
  output logic [DATA_W-1:0] hst_dout,
  output logic              in_full,
  output logic              out_empty,
  input  logic              int_ctl_wr,
  input  logic [CTL_W-1:0]  int_ctl_data,
  input  logic              int_in_rd,
  output logic [DATA_W-1:0] int_in_data,
  input  logic              int_out_wr,
  input  logic [DATA_W-1:0] int_out_data
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  ctl_t              ctl_q, ctl_d;
  logic              data_rd_evt, data_wr_evt, stat_rd_evt;
  logic [DATA_W-1:0] rd_view;
  logic              underrun;
  logic [DATA_W-1:0] status_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_comb ctl_d = int_ctl_wr ? ctl_t'(int_ctl_data) : ctl_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        ctl_q <= '0;
    else if (int_ctl_wr) ctl_q <= ctl_d;
  end

  hpp_strobe_dec u_dec (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .style       (ctl_q.style),
    .rd_ds_n     (hst_rd_ds_n),
    .wr_rw       (hst_wr_rw),
    .stat_sel    (hst_stat_sel),
    .data_rd_evt (data_rd_evt),
    .data_wr_evt (data_wr_evt),
    .stat_rd_evt (stat_rd_evt)
  );

  hpp_in_path #(.DATA_W(DATA_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_evt   (data_wr_evt),
    .narrow   (ctl_q.narrow),
    .word16   (ctl_q.word16),
    .hi_byte  (hst_hi_byte),
    .din      (hst_din),
    .int_rd   (int_in_rd),
    .clr_pair (int_ctl_wr),
    .in_data  (int_in_data),
    .in_full  (in_full)
  );

  hpp_out_path #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_evt    (data_rd_evt),
    .narrow    (ctl_q.narrow),
    .word16    (ctl_q.word16),
    .hi_byte   (hst_hi_byte),
    .int_wr    (int_out_wr),
    .int_data  (int_out_data),
    .clr_pair  (int_ctl_wr),
    .rd_view   (rd_view),
    .out_empty (out_empty),
    .underrun  (underrun)
  );

  always_comb begin
    status_word           = '0;
    status_word[ST_FULL]  = in_full;
    status_word[ST_EMPTY] = out_empty;
    status_word[ST_UNDER] = underrun;
    hst_dout = hst_stat_sel ? status_word : rd_view;
  end

  // R9: a status read leaves every flag as it was
  assert_status_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stat_rd_evt && !int_in_rd && !int_out_wr && !int_ctl_wr)
      |=> ($stable(in_full) && $stable(out_empty) && $stable(underrun)));

  // R1: flags leave their reset values only through an access
  assert_empty_needs_load_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_empty && !int_out_wr) |=> out_empty);

endmodule

// File: tb/test_hpp_host_port.sv
module test_hpp_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk, rst_n;
  logic          hst_rd_ds_n, hst_wr_rw, hst_hi_byte, hst_stat_sel;
  logic [DW-1:0] hst_din, hst_dout, int_in_data, int_out_data;
  logic          in_full, out_empty, int_ctl_wr, int_in_rd, int_out_wr;
  logic [2:0]    int_ctl_data;

  hpp_host_port #(.DATA_W(DW)) i_hpp_host_port (
    .clk(clk), .rst_n(rst_n), .hst_rd_ds_n(hst_rd_ds_n), .hst_wr_rw(hst_wr_rw),
    .hst_hi_byte(hst_hi_byte), .hst_stat_sel(hst_stat_sel), .hst_din(hst_din),
    .hst_dout(hst_dout), .in_full(in_full), .out_empty(out_empty),
    .int_ctl_wr(int_ctl_wr), .int_ctl_data(int_ctl_data), .int_in_rd(int_in_rd),
    .int_in_data(int_in_data), .int_out_wr(int_out_wr), .int_out_data(int_out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] m_in, m_out;
  logic m_full, m_empty, m_und, m_pw, m_pr, m_style, m_narrow, m_w16;

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_view(logic [DW-1:0] r, logic nar, logic w16, logic hi);
    if (!nar) return r;
    if (w16 && hi) return {8'h00, r[15:8]};
    return {8'h00, r[7:0]};
  endfunction

  function automatic logic [DW-1:0] exp_status();
    return {13'd0, m_und, m_empty, m_full};
  endfunction

  task automatic chk_state(string req);
    @(negedge clk);
    chk(req, {14'd0, out_empty, in_full}, {14'd0, m_empty, m_full});
    chk(req, int_in_data, m_in);
  endtask

  task automatic set_ctl(logic st, logic nar, logic w16);
    @(negedge clk);
    int_ctl_wr = 1; int_ctl_data = {w16, nar, st};
    @(negedge clk);
    int_ctl_wr = 0;
    m_style = st; m_narrow = nar; m_w16 = w16; m_pw = 0; m_pr = 0;
  endtask

  task automatic host_wr(logic [DW-1:0] d, logic hi, logic st);
    @(negedge clk);
    hst_din = d; hst_hi_byte = hi; hst_stat_sel = st;
    hst_wr_rw = 0;
    if (m_style) hst_rd_ds_n = 0;
    @(negedge clk);
    hst_wr_rw = 1; hst_rd_ds_n = 1; hst_stat_sel = 0;
    if (!st) begin
      if (!m_narrow) begin m_in = d; m_full = 1; end
      else if (!m_w16) begin m_in = {8'h00, d[7:0]}; m_full = 1; end
      else begin
        if (hi) m_in[15:8] = d[7:0]; else m_in[7:0] = d[7:0];
        if (m_pw) begin m_full = 1; m_pw = 0; end else m_pw = 1;
      end
    end
  endtask

  task automatic host_rd(logic hi, logic st, string req);
    logic [DW-1:0] exp;
    @(negedge clk);
    hst_hi_byte = hi; hst_stat_sel = st; hst_wr_rw = 1; hst_rd_ds_n = 0;
    exp = st ? exp_status() : exp_view(m_out, m_narrow, m_w16, hi);
    #1 chk(req, hst_dout, exp);
    @(negedge clk);
    hst_rd_ds_n = 1; hst_stat_sel = 0;
    if (!st) begin
      if (m_empty) m_und = 1;
      else if (m_narrow && m_w16) begin
        if (m_pr) begin m_empty = 1; m_pr = 0; end else m_pr = 1;
      end else m_empty = 1;
    end
  endtask

  task automatic int_rd();
    @(negedge clk); int_in_rd = 1;
    @(negedge clk); int_in_rd = 0;
    m_full = 0;
  endtask

  task automatic int_wr(logic [DW-1:0] d);
    @(negedge clk); int_out_wr = 1; int_out_data = d;
    @(negedge clk); int_out_wr = 0;
    m_out = d; m_empty = 0; m_und = 0; m_pr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    clk = 0; rst_n = 0;
    hst_rd_ds_n = 1; hst_wr_rw = 1; hst_hi_byte = 0; hst_stat_sel = 0; hst_din = '0;
    int_ctl_wr = 0; int_ctl_data = '0; int_in_rd = 0; int_out_wr = 0; int_out_data = '0;
    m_in = '0; m_out = '0; m_full = 0; m_empty = 1; m_und = 0; m_pw = 0; m_pr = 0;
    m_style = 0; m_narrow = 0; m_w16 = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_state("R1");
    host_rd(0, 1, "R1 status after reset");

    // R2 wide write, split strobes
    host_wr(16'hA5C3, 0, 0);
    chk_state("R2");
    // R7 consume clears full
    int_rd();
    chk_state("R7 consume");
    // R7, R10 load and wide read (byte select ignored)
    int_wr(16'h1234);
    chk_state("R7 load");
    host_rd(1, 0, "R10 wide read");
    chk_state("R10 drained");
    // R8 underrun
    host_rd(0, 0, "R8 empty read returns last");
    chk_state("R8 flags unchanged");
    host_rd(0, 1, "R8 underrun bit");
    int_wr(16'h4321);
    host_rd(0, 1, "R7 load clears underrun");

    // R3 direction-strobe style
    set_ctl(1, 0, 0);
    host_wr(16'hBEEF, 0, 0);
    chk_state("R3 write");
    int_rd();
    repeat (3) begin
      @(negedge clk); hst_wr_rw = 0;
      @(negedge clk); hst_wr_rw = 1;
    end
    chk_state("R3 direction alone");
    host_rd(0, 0, "R3 read");
    chk_state("R3 read drained");

    // R4 single bytes on 8-bit bus
    set_ctl(0, 1, 0);
    host_wr(16'h77AB, 0, 0);
    chk_state("R4 write");
    int_rd();
    int_wr(16'h5566);
    host_rd(1, 0, "R4 read");
    chk_state("R4 drained");

    // R5, R6 words as byte pairs
    set_ctl(0, 1, 1);
    host_wr(16'hFF11, 0, 0);
    chk_state("R5 first byte");
    host_wr(16'hEE22, 1, 0);
    chk_state("R5 second byte");
    int_rd();
    int_wr(16'h9ABC);
    host_rd(1, 0, "R6 high byte");
    chk_state("R6 first read");
    host_rd(0, 0, "R6 low byte");
    chk_state("R6 second read");

    // R9 status select
    host_wr(16'hDEAD, 0, 1);
    host_wr(16'hDEAD, 1, 1);
    chk_state("R9 write ignored");
    int_wr(16'h0F0F);
    host_rd(0, 1, "R9 status read");
    chk_state("R9 status read quiet");

    // R11 control write drops a half pair
    host_wr(16'h0033, 0, 0);
    set_ctl(0, 1, 1);
    host_wr(16'h0044, 1, 0);
    chk_state("R11 restarted pair");
    host_wr(16'h0055, 0, 0);
    chk_state("R11 pair complete");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: set_ctl(1'($urandom), 1'($urandom), 1'($urandom));
        1, 2, 3: host_wr(16'($urandom), 1'($urandom), ($urandom % 8) == 0);
        4, 5, 6: host_rd(1'($urandom), 0, "R2-mix read");
        7: int_rd();
        8: int_wr(16'($urandom));
        default: host_rd(0, 1, "R9 mix status");
      endcase
      chk_state("R5 mix state");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule